// File: doc/BRIEF.md
# Serial Eight-Channel Switch Control Latch

This block is the logic side of an eight-channel on/off driver that a host controls over a four-wire serial link. The host lowers a select line and clocks a byte in, most significant bit first. When it raises the select line again, that byte is copied into a parallel latch whose bits drive the eight channel enables. A bit value of 1 switches its channel on and a 0 switches it off. Devices of this kind can be chained: the serial output of one feeds the serial input of the next. While a frame is in progress, the internal register behaves as a plain shift register, so longer frames carry data on to the devices further down the chain.

The latch is protected against malformed frames. A small edge counter runs for each frame, and the latch is updated only when the number of rising serial-clock edges seen while select was low is a non-zero multiple of eight. A frame that is too short, too long, empty, or padded by a glitch on the clock line leaves the channels as they were. A separate active-low kill input clears the latch and the shift register at once, without waiting for a clock. The channels then stay off until a complete valid frame arrives.

All serial inputs are sampled by a faster system clock. They pass through a two-stage synchronizer and are then edge-detected. The tri-state serial output is represented as a data signal plus an enable signal.

Top module: `serial_switch_latch`

## Requirements
- R1: After reset `chan_on` is 0 and `sdata_oe` is 0.
- R2: A frame of exactly 8 clock edges loads the received byte into `chan_on`. The first bit received lands in `chan_on[7]` and the last bit received in `chan_on[0]`.
- R3: A frame of 8·k edges (k ≥ 1) loads the last 8 bits received into `chan_on`. The earlier bits pass through the register toward the next device in the chain.
- R4: A frame whose edge count is not a multiple of 8 leaves `chan_on` unchanged. The shift register still holds the last 8 bits shifted in.
- R5: A frame with no clock edges leaves `chan_on` unchanged.
- R6: While `sel_n` is high, activity on `sclk_in` and `sdata_in` changes neither `chan_on` nor the shift register, and `sdata_oe` is 0.
- R7: While `sel_n` is low, `sdata_oe` is 1. Once select falls, `sdata_out` shows the register MSB, and after each falling edge of `sclk_in` it shows the new MSB. Just before the k-th rising edge, `sdata_out` therefore shows the bit that will leave the register on that edge.
- R8: A low level on `kill_n` clears `chan_on` at once, asynchronously, and holds it at 0 while `kill_n` stays low.
- R9: After `kill_n` returns high, `chan_on` stays 0 and the shift register reads back as 0 until a new valid frame completes.
- R10: If a kill and a frame commit fall in the same cycle, the kill wins and `chan_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kill_n | input | 1 | Asynchronous active-low disable; clears latch and register |
| sel_n | input | 1 | Active-low frame select |
| sclk_in | input | 1 | Serial clock; data sampled on its rising edge |
| sdata_in | input | 1 | Serial data in, MSB first |
| sdata_out | output | 1 | Serial data out toward the next device in the chain |
| sdata_oe | output | 1 | Drive enable for `sdata_out` (0 = high impedance) |
| chan_on | output | 8 | Channel enables held by the output latch |

## Verification
Two events can land in the same system-clock cycle: the frame commit triggered by select rising, and the asynchronous kill. The bench raises `sel_n` and drops `kill_n` on the same clock phase at the end of a valid frame, then keeps kill low for several cycles. It passes only if the channels read 0 both immediately and after release. A second collision happens inside the edge counter: the restart on select falling versus a serial-clock edge. The bench sweeps frame lengths from 0 to 24 edges, so the boundaries on both sides of each multiple of eight are covered, and it compares the latch and the serial output bit by bit against an arithmetic model.

// File: rtl/sw_pkg.sv
package sw_pkg;
  // Edge-detected view of one synchronized input.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;

  // Index of each serial input within the synchronizer bank.
  localparam int IDX_SEL  = 0;
  localparam int IDX_SCLK = 1;
  localparam int IDX_DATA = 2;
  localparam int N_IN     = 3;
endpackage

// File: rtl/sw_rst_sync.sv
module sw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic arst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= {q[STAGES-2:0], 1'b1};
  end

  assign arst_n = q[STAGES-1];
endmodule

// File: rtl/sw_in_sync.sv
module sw_in_sync
  import sw_pkg::*;
#(
  parameter int             N       = N_IN,
  parameter logic [N-1:0]   IDLE    = '0,
  parameter int             STAGES  = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [N-1:0]  raw,
  output edge_t [N-1:0] ev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        chain <= {STAGES{IDLE[i]}};
        prev  <= IDLE[i];
      end else begin
        chain <= {chain[STAGES-2:0], raw[i]};
        prev  <= chain[STAGES-1];
      end
    end

    assign ev[i].lvl  = chain[STAGES-1];
    assign ev[i].rise = chain[STAGES-1] & ~prev;
    assign ev[i].fall = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/sw_frame.sv
module sw_frame #(
  parameter int W = 8,
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         sel_lvl,
  input  logic         sel_fall,
  input  logic         sel_rise,
  input  logic         ck_rise,
  input  logic         ck_fall,
  input  logic         din,
  output logic         dout,
  output logic         doe,
  output logic [W-1:0] word,
  output logic         frame_ok
);
  logic [W-1:0]     sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             nz_q, nz_d;
  logic             dq_q, dq_d;
  logic             oe_q, oe_d;
  logic             shift_en;

  assign shift_en = ~sel_lvl & ck_rise;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    nz_d  = nz_q;
    dq_d  = dq_q;
    oe_d  = ~sel_lvl;
    if (sel_fall) begin
      cnt_d = '0;
      nz_d  = 1'b0;
    end
    if (shift_en) begin
      sr_d  = {sr_q[W-2:0], din};
      cnt_d = cnt_d + CNT_W'(1);
      nz_d  = 1'b1;
    end
    if (sel_fall || (~sel_lvl && ck_fall)) dq_d = sr_q[W-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      nz_q  <= 1'b0;
      dq_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      nz_q  <= nz_d;
      dq_q  <= dq_d;
      oe_q  <= oe_d;
    end
  end

  assign word     = sr_q;
  assign frame_ok = sel_rise & nz_q & (cnt_q == '0);
  assign dout     = oe_q & dq_q;
  assign doe      = oe_q;

  // R3/R4: a nonzero residue can only exist once an edge has been counted
  a_r4_count_flag: assert property (@(posedge clk) disable iff (!arst_n)
    (cnt_q != '0) |-> nz_q);

  // R6: a select held high for two samples leaves the output undriven
  a_r6_oe_idle: assert property (@(posedge clk) disable iff (!arst_n)
    (sel_lvl && $past(sel_lvl)) |=> !oe_q);

  // R7: the serial output bit moves only after a clock fall or select fall
  a_r7_sdo_timing: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(dq_q) |-> $past(ck_fall || sel_fall));
endmodule

// File: rtl/sw_latch.sv
module sw_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end
endmodule

// File: rtl/serial_switch_latch.sv
module serial_switch_latch
  import sw_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kill_n,
  input  logic                sel_n,
  input  logic                sclk_in,
  input  logic                sdata_in,
  output logic                sdata_out,
  output logic                sdata_oe,
  output logic [CHANNELS-1:0] chan_on
);
  localparam logic [N_IN-1:0] IDLE_LVL = N_IN'((1 << IDX_SEL) | (1 << IDX_SCLK));

  logic                clr_n;
  logic                arst_n;
  logic [N_IN-1:0]     raw;
  edge_t [N_IN-1:0]    ev;
  logic [CHANNELS-1:0] word;
  logic                frame_ok;

  assign clr_n = rst_n & kill_n;

  sw_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .clr_n  (clr_n),
    .arst_n (arst_n)
  );

  always_comb begin
    raw           = '0;
    raw[IDX_SEL]  = sel_n;
    raw[IDX_SCLK] = sclk_in;
    raw[IDX_DATA] = sdata_in;
  end

  sw_in_sync #(.N(N_IN), .IDLE(IDLE_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .raw    (raw),
    .ev     (ev)
  );

  sw_frame #(.W(CHANNELS)) u_frame (
    .clk      (clk),
    .arst_n   (arst_n),
    .sel_lvl  (ev[IDX_SEL].lvl),
    .sel_fall (ev[IDX_SEL].fall),
    .sel_rise (ev[IDX_SEL].rise),
    .ck_rise  (ev[IDX_SCLK].rise),
    .ck_fall  (ev[IDX_SCLK].fall),
    .din      (ev[IDX_DATA].lvl),
    .dout     (sdata_out),
    .doe      (sdata_oe),
    .word     (word),
    .frame_ok (frame_ok)
  );

  sw_latch #(.W(CHANNELS)) u_latch (
    .clk    (clk),
    .arst_n (arst_n),
    .load   (frame_ok),
    .d      (word),
    .q      (chan_on)
  );

  // R4: channel enables change only right after a detected select rise
  a_r4_hold_unless_commit: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(chan_on) |-> $past(ev[IDX_SEL].rise));

  // R8: kill held low keeps every channel off
  a_r8_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_n |-> (chan_on == '0));

  // R6: a high select that persists keeps the serial output undriven
  a_r6_no_drive_idle: assert property (@(posedge clk) disable iff (!arst_n)
    (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3)) |-> !sdata_oe);
endmodule

// File: tb/tb_serial_switch_latch.sv
`timescale 1ns/1ps
module tb_serial_switch_latch;
  logic       clk = 1'b0;
  logic       rst_n, kill_n, sel_n, sclk_in, sdata_in;
  logic       sdata_out, sdata_oe;
  logic [7:0] chan_on;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0] m_sr  = '0;
  logic [7:0] m_lat = '0;

  always #4 clk = ~clk;

  serial_switch_latch dut (
    .clk(clk), .rst_n(rst_n), .kill_n(kill_n), .sel_n(sel_n),
    .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .chan_on(chan_on)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Frame of n edges; bits[n-1] is sent first. Checks serial output per bit.
  task automatic frame(input logic [31:0] bits, input int n, input string req);
    int bad = 0;
    int oe_bad = 0;
    sel_n = 1'b0;
    wait_n(6);
    for (int k = n - 1; k >= 0; k--) begin
      sclk_in  = 1'b0;
      sdata_in = bits[k];
      wait_n(5);
      if (sdata_out !== m_sr[7]) bad++;
      if (sdata_oe !== 1'b1) oe_bad++;
      sclk_in = 1'b1;
      m_sr = {m_sr[6:0], bits[k]};
      wait_n(5);
    end
    if (n == 0 && sdata_oe !== 1'b1) oe_bad++;
    sel_n = 1'b1;
    wait_n(6);
    if (n > 0 && (n % 8) == 0) m_lat = m_sr;
    check({req, " R7 sdo bits"}, bad, 0);
    check({req, " R7 oe"}, oe_bad, 0);
    check({req, " latch"}, chan_on, m_lat);
    check({req, " R6 oe idle"}, sdata_oe, 1'b0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; kill_n = 1'b1; sel_n = 1'b1; sclk_in = 1'b1; sdata_in = 1'b0;
    wait_n(4);
    check("R1 chan_on", chan_on, 8'h00);
    check("R1 oe", sdata_oe, 1'b0);
    rst_n = 1'b1;
    wait_n(4);

    // R2: every byte value in single-byte frames
    for (int v = 0; v < 256; v++) frame(32'(v), 8, "R2");

    // R3/R4/R5: frame lengths 0..24 with a fixed pattern
    for (int n = 0; n <= 24; n++) begin
      logic [31:0] pat = 32'h6C3A_95E1 ^ 32'(n * 32'h0101_0101);
      if (n == 0) frame(pat, n, "R5");
      else if (n % 8 == 0) frame(pat, n, "R3");
      else frame(pat, n, "R4");
    end

    // R6: activity on clock and data while deselected has no effect
    frame(32'h0000_00C5, 8, "R6 setup");
    for (int i = 0; i < 20; i++) begin
      sclk_in = i[0]; sdata_in = i[1];
      wait_n(4);
      if (sdata_oe !== 1'b0) check("R6 oe during toggle", sdata_oe, 1'b0);
    end
    sclk_in = 1'b1;
    wait_n(4);
    check("R6 latch after toggles", chan_on, m_lat);
    frame(32'h0000_1234, 16, "R6 register kept");

    // R8/R9: asynchronous kill then recovery
    frame(32'h0000_00A5, 8, "R8 setup");
    @(negedge clk);
    kill_n = 1'b0;
    #1;
    check("R8 immediate clear", chan_on, 8'h00);
    wait_n(3);
    check("R8 held low", chan_on, 8'h00);
    kill_n = 1'b1;
    m_sr = '0; m_lat = '0;
    wait_n(6);
    check("R9 off after release", chan_on, 8'h00);
    frame(32'h0000_0005, 3, "R9 invalid after kill");
    check("R9 still off", chan_on, 8'h00);
    frame(32'h0000_003C, 8, "R9 new write");

    // R10: kill lands on the same phase as the commit
    sel_n = 1'b0;
    wait_n(6);
    for (int k = 7; k >= 0; k--) begin
      sclk_in = 1'b0; sdata_in = k[0]; wait_n(5);
      sclk_in = 1'b1; wait_n(5);
    end
    sel_n = 1'b1;
    kill_n = 1'b0;
    #1;
    check("R10 kill vs commit now", chan_on, 8'h00);
    wait_n(5);
    check("R10 kill vs commit held", chan_on, 8'h00);
    kill_n = 1'b1;
    wait_n(6);
    check("R10 after release", chan_on, 8'h00);
    m_sr = '0; m_lat = '0;
    frame(32'h0000_0081, 8, "R10 recovery");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule